// File: doc/BRIEF.md
# E3 Receive Overhead Marker Generator

This block sits behind the frame aligner of an E3 receive path and walks through every received bit of an already aligned 1536-bit frame. For each valid bit it produces qualifiers: a sync marker that is high across the frame's overhead field, an overhead indicator that is low across the same field, and an info-bit enable that is high only for the payload bits. The received bit leaves the block on the same register stage as its qualifiers, so the outputs are aligned with one another.

The overhead field normally holds 12 bits: a 10-bit alignment word, then the A bit and the N bit. With the extension enable set, the field grows to 16 bits. The four extra bits must carry the fixed pattern 1100, and the payload shrinks from 1524 to 1520 bits. The block checks those four bits and pulses an error flag when they do not match. A mode change takes effect only at a frame boundary.

Top module: `e3_ovh_marker`

## Requirements
- R1: After reset, and until the first bit that carries `frameStart`, the outputs hold `syncMark`=0, `ovhN`=1, `infoEn`=0 and `patErr`=0. This holds even while bits are valid.
- R2: A valid bit with `frameStart`=1 is frame position 0 at any point in the frame. Each later valid bit advances the position by one, and the position wraps from 1535 to 0 without a new pulse.
- R3: In normal mode, positions 0 to 11 are overhead. `syncMark` is 1 and `ovhN` is 0 for those positions, and the opposite holds for positions 12 to 1535. That gives 12 sync bits per frame.
- R4: In extended mode, positions 0 to 15 are overhead, with the same polarities as R3. That gives 16 sync bits per frame.
- R5: `infoEn` is 1 for a valid bit outside the overhead field and 0 otherwise. A full frame carries 1524 enabled bits in normal mode and 1520 in extended mode.
- R6: `extEn` is sampled only on the position-0 bit. That mode governs the whole frame, so changing `extEn` in mid-frame changes nothing until the next position 0.
- R7: In extended mode, the bits at positions 12, 13, 14 and 15 must be 1, 1, 0 and 0. If any of them differs, `patErr` is 1 for exactly one output cycle: the cycle that carries position 15. `patErr` never rises in normal mode.
- R8: Every output updates one clock after the edge that samples a valid bit, and `dataOut` then equals that bit. On a clock without a valid bit, `infoEn` and `patErr` go to 0, and `dataOut`, `syncMark` and `ovhN` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe: rxBit carries a bit this cycle |
| frameStart | input | 1 | Marks the current valid bit as frame position 0 |
| extEn | input | 1 | Extended 16-bit overhead mode enable |
| rxBit | input | 1 | Received serial bit |
| dataOut | output | 1 | Registered copy of the received bit |
| syncMark | output | 1 | High across the overhead field |
| ovhN | output | 1 | Low across the overhead field |
| infoEn | output | 1 | High for valid payload bits |
| patErr | output | 1 | One-cycle pulse on a bad extension pattern |

## Verification
The pattern checker's closing step at position 15 can fall in the same cycle as a frame-start resynchronisation. The bench provokes this by corrupting position 13 in extended mode and then asserting `frameStart` on the bit that would have been position 15. The restart must win: that output cycle is judged for `patErr`=0 with `syncMark`=1. The whole 16-bit window then replays from position 0, and a clean pattern in it must raise no error.

// File: rtl/e3_ovh_pkg.sv
package e3_ovh_pkg;

  // Per-bit strobes passed from the position control to the output datapath
  typedef struct packed {
    logic valid;     // a bit is present this cycle
    logic armed;     // a frame start has been seen (including this bit)
    logic inOvh;     // the current bit lies in the overhead window
    logic patCheck;  // the current bit is one of the extension pattern bits
    logic patFirst;  // the first pattern bit
    logic patLast;   // the last pattern bit
    logic patExp;    // the expected value of the current pattern bit
  } ctrlStrobes_t;

endpackage

// File: rtl/e3_ovh_ctrl.sv
module e3_ovh_ctrl
  import e3_ovh_pkg::*;
#(
  parameter int FRAME_LEN = 1536,
  parameter int BASE_OVH  = 12,
  parameter int EXT_OVH   = 4,
  parameter logic [EXT_OVH-1:0] EXT_PATTERN = 4'b1100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitValid,
  input  logic         frameStart,
  input  logic         extEn,
  output ctrlStrobes_t strobes
);

  localparam int CW        = $clog2(FRAME_LEN);
  localparam int IW        = $clog2(EXT_OVH);
  localparam int EXT_TOTAL = BASE_OVH + EXT_OVH;
  localparam logic [CW-1:0] LAST_POS  = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] BASE_LEN  = CW'(BASE_OVH);
  localparam logic [CW-1:0] EXT_LEN   = CW'(EXT_TOTAL);
  localparam logic [CW-1:0] PAT_LAST  = CW'(EXT_TOTAL - 1);

  logic [CW-1:0] nextPos;
  logic [CW-1:0] curPos;
  logic [CW-1:0] patIdx;
  logic          armed;
  logic          curExt;
  logic          restart;
  logic          armedNow;
  logic          modeNow;
  logic          inPatRange;
  logic [EXT_OVH-1:0] patRev;

  // Flip the pattern so that index 0 is the first bit on the line
  for (genvar g = 0; g < EXT_OVH; g++) begin : g_patRev
    assign patRev[g] = EXT_PATTERN[EXT_OVH-1-g];
  end

  always_comb begin
    restart    = bitValid && frameStart;
    curPos     = restart ? '0 : nextPos;
    armedNow   = armed || restart;
    modeNow    = (curPos == '0) ? extEn : curExt;
    patIdx     = curPos - BASE_LEN;
    inPatRange = (curPos >= BASE_LEN) && (curPos < EXT_LEN);

    strobes.valid    = bitValid;
    strobes.armed    = armedNow;
    strobes.inOvh    = curPos < (modeNow ? EXT_LEN : BASE_LEN);
    strobes.patCheck = bitValid && armedNow && modeNow && inPatRange;
    strobes.patFirst = curPos == BASE_LEN;
    strobes.patLast  = curPos == PAT_LAST;
    strobes.patExp   = patRev[patIdx[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPos <= '0;
      armed   <= 1'b0;
      curExt  <= 1'b0;
    end else if (bitValid) begin
      armed   <= armedNow;
      curExt  <= modeNow;
      nextPos <= (curPos == LAST_POS) ? '0 : curPos + 1'b1;
    end
  end

endmodule

// File: rtl/e3_ovh_dpath.sv
module e3_ovh_dpath
  import e3_ovh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxBit,
  input  ctrlStrobes_t strobes,
  output logic         dataOut,
  output logic         syncMark,
  output logic         ovhN,
  output logic         infoEn,
  output logic         patErr
);

  logic missAcc;
  logic missNow;
  logic accNext;
  logic markNow;

  always_comb begin
    missNow = strobes.patCheck && (rxBit != strobes.patExp);
    accNext = strobes.patFirst ? missNow : (missAcc || missNow);
    markNow = strobes.armed && strobes.inOvh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut  <= 1'b0;
      syncMark <= 1'b0;
      ovhN     <= 1'b1;
      infoEn   <= 1'b0;
      patErr   <= 1'b0;
      missAcc  <= 1'b0;
    end else begin
      infoEn <= 1'b0;
      patErr <= 1'b0;
      if (strobes.valid) begin
        dataOut  <= rxBit;
        syncMark <= markNow;
        ovhN     <= !markNow;
        infoEn   <= strobes.armed && !strobes.inOvh;
        if (strobes.patCheck) begin
          missAcc <= accNext;
          patErr  <= strobes.patLast && accNext;
        end
      end
    end
  end

endmodule

// File: rtl/e3_ovh_marker.sv
module e3_ovh_marker
  import e3_ovh_pkg::*;
#(
  parameter int FRAME_LEN = 1536,
  parameter int BASE_OVH  = 12,
  parameter int EXT_OVH   = 4,
  parameter logic [EXT_OVH-1:0] EXT_PATTERN = 4'b1100
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic frameStart,
  input  logic extEn,
  input  logic rxBit,
  output logic dataOut,
  output logic syncMark,
  output logic ovhN,
  output logic infoEn,
  output logic patErr
);

  ctrlStrobes_t strobes;

  e3_ovh_ctrl #(
    .FRAME_LEN  (FRAME_LEN),
    .BASE_OVH   (BASE_OVH),
    .EXT_OVH    (EXT_OVH),
    .EXT_PATTERN(EXT_PATTERN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitValid  (bitValid),
    .frameStart(frameStart),
    .extEn     (extEn),
    .strobes   (strobes)
  );

  e3_ovh_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .rxBit   (rxBit),
    .strobes (strobes),
    .dataOut (dataOut),
    .syncMark(syncMark),
    .ovhN    (ovhN),
    .infoEn  (infoEn),
    .patErr  (patErr)
  );

endmodule

// File: rtl/e3_ovh_marker_chk.sv
module e3_ovh_marker_chk (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic frameStart,
  input logic rxBit,
  input logic dataOut,
  input logic syncMark,
  input logic ovhN,
  input logic infoEn,
  input logic patErr
);

  logic seen;

  always_ff @(posedge clk) begin
    if (!rstN) seen <= 1'b0;
    else if (bitValid && frameStart) seen <= 1'b1;
  end

  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !seen |-> (!syncMark && ovhN && !infoEn && !patErr));

  a_r2_start_marks: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && bitValid) |=> syncMark);

  a_r3_polarity: assert property (@(posedge clk) disable iff (!rstN)
    syncMark != ovhN);

  a_r5_info_outside: assert property (@(posedge clk) disable iff (!rstN)
    infoEn |-> (!syncMark && ovhN));

  a_r7_err_in_window: assert property (@(posedge clk) disable iff (!rstN)
    patErr |-> syncMark);

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rstN)
    patErr |=> !patErr);

  a_r8_data_follow: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> (dataOut == $past(rxBit)));

  a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> (!infoEn && !patErr && $stable(syncMark) && $stable(dataOut)));

endmodule

bind e3_ovh_marker e3_ovh_marker_chk u_chk (.*);

// File: tb/e3_ovh_marker_test.sv
`timescale 1ns/1ps
module e3_ovh_marker_test;

  localparam int FLEN = 1536;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic frameStart = 1'b0;
  logic extEn = 1'b0;
  logic rxBit = 1'b0;
  logic dataOut, syncMark, ovhN, infoEn, patErr;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // bench-side model of the requirements
  bit mArmed = 0;
  int mNext = 0;
  bit mExt = 0;
  bit mMiss = 0;
  logic eData = 0, eSync = 0, eOvhN = 1;
  int infoCnt = 0, syncCnt = 0, errCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  e3_ovh_marker uut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .frameStart(frameStart),
    .extEn(extEn), .rxBit(rxBit), .dataOut(dataOut), .syncMark(syncMark),
    .ovhN(ovhN), .infoEn(infoEn), .patErr(patErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, then compare all outputs against the model
  task automatic stepBit(input logic b, input logic fs, input logic v);
    bit restart, armedN, modeN, win, eInfo, eErr, miss, patPos;
    int pos;
    restart = v && fs;
    pos     = restart ? 0 : mNext;
    armedN  = mArmed || restart;
    modeN   = (pos == 0) ? extEn : mExt;
    win     = pos < (modeN ? 16 : 12);
    patPos  = v && armedN && modeN && pos >= 12 && pos < 16;
    miss    = patPos && (b != ((pos == 12 || pos == 13) ? 1'b1 : 1'b0));
    eInfo   = 0;
    eErr    = 0;
    if (v) begin
      eData = b;
      eSync = armedN && win;
      eOvhN = !(armedN && win);
      eInfo = armedN && !win;
      if (patPos) begin
        mMiss = (pos == 12) ? miss : (mMiss || miss);
        eErr  = (pos == 15) && mMiss;
      end
      mArmed = armedN;
      mExt   = modeN;
      mNext  = (pos == FLEN - 1) ? 0 : pos + 1;
    end
    bitValid = v; frameStart = fs; rxBit = b;
    @(posedge clk); #1;
    bitValid = 0; frameStart = 0;
    check(syncMark == eSync, modeN ? "R4 syncMark" : "R3 syncMark", syncMark, eSync);
    check(ovhN == eOvhN, modeN ? "R4 ovhN" : "R3 ovhN", ovhN, eOvhN);
    check(infoEn == eInfo, "R5 infoEn", infoEn, eInfo);
    check(patErr == eErr, "R7 patErr", patErr, eErr);
    check(dataOut == eData, "R8 dataOut", dataOut, eData);
    if (infoEn) infoCnt++;
    if (syncMark && v) syncCnt++;
    if (patErr) errCnt++;
  endtask

  // one valid bit; pattern bits are placed correctly unless badPos names them
  task automatic sendBits(input int n, input bit fsFirst, input int badPos);
    for (int i = 0; i < n; i++) begin
      int pos;
      logic b;
      pos = (fsFirst && i == 0) ? 0 : mNext;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pos >= 12 && pos < 16) b = (pos < 14) ? 1'b1 : 1'b0;
      else b = lfsr[0];
      if (pos == badPos) b = ~b;
      stepBit(b, fsFirst && i == 0, 1'b1);
    end
  endtask

  task automatic clearCounts();
    infoCnt = 0; syncCnt = 0; errCnt = 0;
  endtask

  task automatic t_reset();
    check(syncMark == 0 && ovhN == 1 && infoEn == 0 && patErr == 0, "R1 reset idle",
          {syncMark, ovhN, infoEn, patErr}, 4'b0100);
    sendBits(40, 0, -1);  // valid bits, no frame start yet
    check(syncMark == 0 && ovhN == 1, "R1 idle before start", {syncMark, ovhN}, 2'b01);
  endtask

  task automatic t_normal();
    extEn = 0;
    clearCounts();
    sendBits(FLEN, 1, -1);
    check(infoCnt == 1524, "R5 normal info count", infoCnt, 1524);
    check(syncCnt == 12, "R3 normal sync count", syncCnt, 12);
    clearCounts();
    sendBits(20, 0, 13);  // wraps without a pulse; pos 13 is payload here
    check(syncCnt == 12, "R2 wrap restarts window", syncCnt, 12);
    check(errCnt == 0, "R7 no error in normal mode", errCnt, 0);
  endtask

  task automatic t_extended();
    extEn = 1;
    clearCounts();
    sendBits(FLEN, 1, -1);
    check(infoCnt == 1520, "R5 extended info count", infoCnt, 1520);
    check(syncCnt == 16, "R4 extended sync count", syncCnt, 16);
    check(errCnt == 0, "R7 clean pattern", errCnt, 0);
  endtask

  task automatic t_badPattern();
    extEn = 1;
    for (int bp = 12; bp < 16; bp++) begin
      clearCounts();
      sendBits(24, 1, bp);
      check(errCnt == 1, "R7 bad pattern flagged once", errCnt, 1);
    end
  endtask

  task automatic t_modeChange();
    extEn = 0;
    clearCounts();
    sendBits(5, 1, -1);
    extEn = 1;  // mid-frame: must wait for the boundary
    sendBits(FLEN - 5, 0, -1);
    check(syncCnt == 12, "R6 mid-frame change deferred", syncCnt, 12);
    clearCounts();
    sendBits(30, 0, -1);
    check(syncCnt == 16, "R6 change applied at boundary", syncCnt, 16);
    extEn = 0;
  endtask

  task automatic t_gaps();
    extEn = 0;
    clearCounts();
    sendBits(20, 1, -1);
    stepBit(1'b1, 1'b0, 1'b0);
    check(infoEn == 0, "R8 no info on gap", infoEn, 0);
    stepBit(1'b0, 1'b1, 1'b0);  // frame start without a valid bit is ignored
    check(syncMark == 0, "R2 start needs valid bit", syncMark, 0);
    sendBits(3, 0, -1);
    check(infoEn == 1, "R5 info resumes after gap", infoEn, 1);
  endtask

  task automatic t_resyncCollide();
    extEn = 1;
    clearCounts();
    sendBits(15, 1, 13);        // positions 0..14 with a bad bit at 13
    sendBits(1, 1, -1);         // restart lands where position 15 would be
    check(patErr == 0, "R2 restart beats pattern close", patErr, 0);
    check(syncMark == 1, "R2 restart is position 0", syncMark, 1);
    sendBits(20, 0, -1);
    check(errCnt == 0, "R7 no error after restart", errCnt, 0);
    sendBits(700, 0, -1);
    clearCounts();
    sendBits(30, 1, -1);        // resync in mid-frame
    check(syncCnt == 16, "R2 mid-frame resync window", syncCnt, 16);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_normal();
    t_extended();
    t_badPattern();
    t_modeChange();
    t_gaps();
    t_resyncCollide();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule